// File: doc/BRIEF.md
# Flash Segment Command Register with Identification Mode

This block is the command front end of one flash memory segment. It watches an asynchronous-style bus made of active-low chip enable, output enable and write enable, all sampled on the system clock. A write cycle opens when write enable falls while the chip is selected and outputs are disabled. The bus address is captured at that falling edge. The command byte is captured at the following rising edge.

The captured byte picks the read personality of the segment. In the normal read mode, reads pass the array data through. In the identification mode, reads return a manufacturer code at word address zero, a device code at address two, and zero at any other address. A write-protect input blocks every write internally. A supply-lockout flag pushes the register back to read mode and blocks writes for as long as it is held.

Top module: `flash_cmd_reg`

## Requirements
- R1: After synchronous reset the register is in read mode (`auto_mode` = 0) and `rdata` equals `arr_rdata`, with no command needed.
- R2: A write cycle counts only if `ce_n` is low and `oe_n` is high from the falling edge of `we_n` through its rising edge. If `ce_n` goes high or `oe_n` goes low in between, the cycle is dropped and the mode does not change.
- R3: The falling edge of `we_n` captures `addr` into `lat_addr`, which is visible one clock later. The rising edge captures `wdata` as the command, and the mode changes on that same clock.
- R4: The command byte 0x90 selects identification mode (`auto_mode` = 1).
- R5: In identification mode, `rdata` is `MFR_ID` when `addr` is 0, `DEV_ID` when `addr` is 2, and 0x00 for any other address.
- R6: The command 0xF0 or 0xFF returns the register to read mode. Identification mode otherwise persists.
- R7: Any other command byte leaves the current mode unchanged.
- R8: While `wp` is high, `we_n` is treated as high. No address is captured and no command is accepted.
- R9: While `lockout` is high, the mode returns to read on the next clock and writes are ignored. Lockout wins over a command that completes in the same clock.
- R10: `data_oe` is high exactly when `ce_n` and `oe_n` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wp | input | 1 | Write-protect switch, high blocks writes |
| lockout | input | 1 | Supply-lockout flag, high forces read mode |
| addr | input | AW | Bus address |
| wdata | input | DW | Bus write data / command byte |
| arr_rdata | input | DW | Data read from the array |
| rdata | output | DW | Read data returned to the bus |
| data_oe | output | 1 | Read data output enable |
| auto_mode | output | 1 | High while in identification mode |
| lat_addr | output | AW | Address captured at the last accepted falling edge |

## Verification
The two functions that can fall in the same clock are the rising edge of write enable, which completes a command, and the assertion of lockout (or write protect). The bench provokes this by raising `lockout` in the same cycle that `we_n` rises with 0x90 on the data bus. It then checks that the mode stays in read, both in that cycle and after lockout clears. A behavioural reference model in the bench follows the bus every clock and compares `rdata`, `auto_mode`, `lat_addr` and `data_oe` against its own prediction.

// File: rtl/fcr_pkg.sv
// Package: shared mode type and command byte codes for the flash command register.
// Assumes 8-bit command bytes.
package fcr_pkg;
    typedef enum logic {
        MODE_READ = 1'b0,
        MODE_AUTO = 1'b1
    } mode_t;

    localparam logic [7:0] CMD_AUTOSEL = 8'h90;
    localparam logic [7:0] CMD_RESET_A = 8'hF0;
    localparam logic [7:0] CMD_RESET_B = 8'hFF;
endpackage

// File: rtl/fcr_strobe.sv
// Write-cycle tracker: finds the edges of the effective write enable.
// It captures the address on a qualified falling edge and pulses cmd_stb on the
// matching qualified rising edge. Assumes bus inputs are synchronous to clk.
module fcr_strobe #(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          wp,
    input  logic          lockout,
    input  logic [AW-1:0] addr,
    output logic          cmd_stb,
    output logic [AW-1:0] lat_addr
);
    logic we_eff;
    logic we_q;
    logic armed;
    logic qual;
    logic fall_ok;

    assign we_eff  = we_n | wp | lockout;
    assign qual    = ~ce_n & oe_n & ~wp & ~lockout;
    assign fall_ok = we_q & ~we_eff & qual;
    assign cmd_stb = ~we_q & we_eff & armed & qual;

    // Remember the previous effective write enable for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) we_q <= 1'b1;
        else        we_q <= we_eff;
    end

    // Open a cycle on a qualified fall; close it on the strobe or a broken qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= 1'b0;
        else if (fall_ok) armed <= 1'b1;
        else if (cmd_stb || !qual) armed <= 1'b0;
    end

    // Capture the bus address on a qualified falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       lat_addr <= '0;
        else if (fall_ok) lat_addr <= addr;
    end

    assert_stb_qual_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> (!ce_n && oe_n));
    assert_wp_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wp |=> $stable(lat_addr));
endmodule

// File: rtl/fcr_mode.sv
// Mode register: decodes strobed command bytes into read / identification mode.
// Lockout has priority over any command. Unknown bytes keep the mode.
module fcr_mode
    import fcr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_stb,
    input  logic [DW-1:0] cmd,
    input  logic          lockout,
    output mode_t         mode
);
    mode_t mode_nx;

    // Work out the next mode from the strobed command byte.
    always_comb begin
        mode_nx = mode;
        if (lockout) begin
            mode_nx = MODE_READ;
        end else if (cmd_stb) begin
            if (cmd[7:0] == CMD_AUTOSEL)
                mode_nx = MODE_AUTO;
            else if (cmd[7:0] == CMD_RESET_A || cmd[7:0] == CMD_RESET_B)
                mode_nx = MODE_READ;
        end
    end

    // Hold the current mode.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= MODE_READ;
        else        mode <= mode_nx;
    end

    assert_reset_read_R1: assert property (@(posedge clk)
        !rst_n |=> mode == MODE_READ);
    assert_lockout_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> mode == MODE_READ);
    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_stb && !lockout) |=> $stable(mode));
endmodule

// File: rtl/fcr_readmux.sv
// Read path: passes array data in read mode and identification codes in
// identification mode. Assumes the word address 2 holds the device code.
module fcr_readmux
    import fcr_pkg::*;
#(
    parameter int          AW     = 20,
    parameter int          DW     = 8,
    parameter logic [DW-1:0] MFR_ID = 8'h01,
    parameter logic [DW-1:0] DEV_ID = 8'hA4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mode_t         mode,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] arr_rdata,
    output logic [DW-1:0] rdata
);
    localparam logic [AW-1:0] ADDR_MFR = '0;
    localparam logic [AW-1:0] ADDR_DEV = AW'(2);

    // Select the read source from mode and address.
    always_comb begin
        if (mode == MODE_READ)      rdata = arr_rdata;
        else if (addr == ADDR_MFR)  rdata = MFR_ID;
        else if (addr == ADDR_DEV)  rdata = DEV_ID;
        else                        rdata = '0;
    end

    assert_id_codes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_AUTO && addr != ADDR_MFR && addr != ADDR_DEV) |-> rdata == '0);
endmodule

// File: rtl/flash_cmd_reg.sv
// Top: per-segment command register with identification mode, write protect
// and supply lockout. Assumes all bus inputs are synchronous to clk.
module flash_cmd_reg
    import fcr_pkg::*;
#(
    parameter int            AW     = 20,
    parameter int            DW     = 8,
    parameter logic [DW-1:0] MFR_ID = 8'h01,
    parameter logic [DW-1:0] DEV_ID = 8'hA4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          wp,
    input  logic          lockout,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] arr_rdata,
    output logic [DW-1:0] rdata,
    output logic          data_oe,
    output logic          auto_mode,
    output logic [AW-1:0] lat_addr
);
    logic  cmd_stb;
    mode_t mode;

    fcr_strobe #(.AW(AW)) u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .wp(wp), .lockout(lockout), .addr(addr),
        .cmd_stb(cmd_stb), .lat_addr(lat_addr)
    );

    fcr_mode #(.DW(DW)) u_mode (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd(wdata),
        .lockout(lockout), .mode(mode)
    );

    fcr_readmux #(.AW(AW), .DW(DW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
        .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr),
        .arr_rdata(arr_rdata), .rdata(rdata)
    );

    assign auto_mode = (mode == MODE_AUTO);
    assign data_oe   = ~ce_n & ~oe_n;

    assert_wp_no_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wp |=> $stable(auto_mode) || !auto_mode);
    assert_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> !data_oe);
endmodule

// File: tb/flash_cmd_reg_tb.sv
module flash_cmd_reg_tb;
    localparam int AW = 20;
    localparam int DW = 8;
    localparam logic [7:0] MFR = 8'h01;
    localparam logic [7:0] DEV = 8'hA4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wp = 1'b0, lockout = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] arr_rdata;
    logic [DW-1:0] rdata;
    logic data_oe, auto_mode;
    logic [AW-1:0] lat_addr;

    int total = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;
    assign arr_rdata = addr[7:0] ^ 8'h5A;

    flash_cmd_reg #(.AW(AW), .DW(DW), .MFR_ID(MFR), .DEV_ID(DEV)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .wp(wp), .lockout(lockout), .addr(addr), .wdata(wdata),
        .arr_rdata(arr_rdata), .rdata(rdata), .data_oe(data_oe),
        .auto_mode(auto_mode), .lat_addr(lat_addr)
    );

    // Behavioural reference model
    bit m_wehi = 1, m_open = 0, m_auto = 0;
    logic [AW-1:0] m_lat = '0;

    always @(posedge clk) begin
        bit eff, ok;
        if (!rst_n) begin
            m_wehi <= 1; m_open <= 0; m_auto <= 0; m_lat <= '0;
        end else begin
            eff = we_n || wp || lockout;
            ok  = !ce_n && oe_n && !wp && !lockout;
            m_wehi <= eff;
            if (m_wehi && !eff && ok) begin
                m_lat <= addr; m_open <= 1;
            end else if (!m_wehi && eff && m_open && ok) begin
                m_open <= 0;
                if (wdata == 8'h90) m_auto <= 1;
                else if (wdata == 8'hF0 || wdata == 8'hFF) m_auto <= 0;
            end else if (!ok) m_open <= 0;
            if (lockout) m_auto <= 0;
        end
    end

    function automatic logic [7:0] exp_rd();
        if (!m_auto) return arr_rdata;
        if (addr == 0) return MFR;
        if (addr == 2) return DEV;
        return 8'h00;
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) if (rst_n && !done) begin
        check("R5 rdata", rdata, exp_rd());
        check("R4 auto_mode", auto_mode, m_auto);
        check("R3 lat_addr", lat_addr, m_lat);
        check("R10 data_oe", data_oe, !ce_n && !oe_n);
    end

    task automatic cyc(int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic bus_wr(logic [AW-1:0] a, logic [7:0] d,
                          bit ce_drop = 0, bit oe_drop = 0, bit lock_at_rise = 0);
        ce_n = 0; oe_n = 1; addr = a; wdata = d; cyc();
        we_n = 0; cyc();
        if (ce_drop) ce_n = 1;
        if (oe_drop) oe_n = 0;
        cyc();
        we_n = 1;
        if (lock_at_rise) lockout = 1;
        cyc();
        ce_n = 1; oe_n = 1; lockout = 0; cyc();
    endtask

    task automatic rd(logic [AW-1:0] a);
        ce_n = 0; oe_n = 0; addr = a; cyc();
    endtask

    initial begin
        cyc(3);
        rst_n = 1; addr = 20'h00010; cyc();
        check("R1 reset mode", auto_mode, 0);
        check("R1 reset rdata", rdata, 8'h10 ^ 8'h5A);

        bus_wr(20'h00555, 8'h90);
        check("R4 enter id", auto_mode, 1);
        check("R3 latched addr", lat_addr, 20'h00555);
        rd(0); check("R5 mfr", rdata, MFR);
        rd(2); check("R5 dev", rdata, DEV);
        rd(1); check("R5 other", rdata, 8'h00);
        rd(20'h00004); check("R5 addr4", rdata, 8'h00);

        bus_wr(20'h00AAA, 8'h55);
        check("R7 unknown keeps id", auto_mode, 1);
        bus_wr(20'h00100, 8'h00);
        check("R6 persists", auto_mode, 1);
        bus_wr(20'h00000, 8'hF0);
        check("R6 F0 reset", auto_mode, 0);
        rd(2); check("R6 array after reset", rdata, 8'h02 ^ 8'h5A);
        bus_wr(20'h00000, 8'h90);
        bus_wr(20'h00000, 8'hFF);
        check("R6 FF reset", auto_mode, 0);
        bus_wr(20'h00000, 8'h33);
        check("R7 unknown keeps read", auto_mode, 0);

        bus_wr(20'h00321, 8'h90, 1, 0);
        check("R2 ce drop ignored", auto_mode, 0);
        bus_wr(20'h00322, 8'h90, 0, 1);
        check("R2 oe drop ignored", auto_mode, 0);
        ce_n = 0; oe_n = 0; we_n = 0; wdata = 8'h90; cyc(2); we_n = 1; cyc();
        ce_n = 1; oe_n = 1; cyc();
        check("R2 oe low whole cycle ignored", auto_mode, 0);

        wp = 1;
        bus_wr(20'h00777, 8'h90);
        check("R8 wp blocks cmd", auto_mode, 0);
        check("R8 wp blocks addr", lat_addr, 20'h00322);
        wp = 0; cyc();

        bus_wr(20'h00000, 8'h90);
        check("R4 id again", auto_mode, 1);
        lockout = 1; cyc();
        check("R9 lockout reset", auto_mode, 0);
        bus_wr(20'h00000, 8'h90);
        lockout = 1; bus_wr(20'h00000, 8'h90);
        check("R9 writes ignored in lockout", auto_mode, 0);
        bus_wr(20'h00000, 8'h90, 0, 0, 1);
        check("R9 lockout beats same-cycle cmd", auto_mode, 0);
        cyc(2);
        check("R9 still read after lockout", auto_mode, 0);

        rd(20'h00003);
        check("R10 oe on", data_oe, 1);
        oe_n = 1; cyc();
        check("R10 oe off", data_oe, 0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule